// File: doc/BRIEF.md
# Panel Frame Timing and Display Enable Controller

This block paces the vertical timing of a flat-panel driver one raster row at a time. Every frame is a run of leading blank rows, then the picture rows, then trailing blank rows. A row-rate tick advances the frame by one row. The block produces five outputs: a row strobe, a frame-start pulse, a level that is high only on picture rows, a liquid-crystal drive polarity that flips once per frame, and a code that tells the source drivers to ground, show blank or show the picture.

Software sets the block through two write-only registers. The porch register holds the leading and trailing blank counts. The control register holds a two-bit run level and an enable for the picture-row level. The run level has four settings: fully stopped, timing running with sources grounded, running but blank, and running with the picture shown. A standby input forces the stopped behaviour and leaves the stored run level untouched. An external-sync mode lets a falling VSYNC edge start each frame in place of the internal row count.

Top module: `panel_frame_timer`

## Requirements
- R1: After synchronous reset all outputs are low, `src_ctl` is 0, the run level is 00 and both porches are 2.
- R2: A frame is `bp` leading rows, `ACTIVE_ROWS` picture rows and `fp` trailing rows. Each row tick enters the next row, so an internal-mode frame lasts `bp+ACTIVE_ROWS+fp` ticks.
- R3: `disp_tmg` is high on picture rows only, and only when control bit 4 (timing enable) is 1. When that bit is 0, `disp_tmg` stays low.
- R4: A write with `wr_sel`=1 loads the porch register: bits 11:8 give the trailing count `fp` and bits 3:0 give the leading count `bp`.
- R5: A porch value below 2 is used as 2. If the two values then add to more than 16, `fp` is used as `16-bp`.
- R6: `frame_start` is a one-clock pulse on the tick that enters the first leading row. `line_strobe` is a one-clock pulse on every tick while the timing runs.
- R7: `ac_pol` flips on every frame start and holds its value while the timing is stopped.
- R8: A write with `wr_sel`=0 loads control bits 1:0 as the run level. Level 00 stops the timing: no strobes and `src_ctl`=0. Level 01 runs with `src_ctl`=0 (ground), level 10 runs with `src_ctl`=1 (blank) and level 11 runs with `src_ctl`=2 (picture).
- R9: While `standby` is 1, a row tick stops the timing as for level 00. The stored level is kept, and the first tick after release starts a new frame using it.
- R10: Porch, enable and nonzero level writes take effect at the next frame start. Level 00 and standby take effect on the next row tick.
- R11: When `ext_mode` is 1, a frame starts on the first row tick at or after a falling edge of `ext_vsync`. Without such an edge the timing stays on the last trailing row.
- R12: Writing level 11 while stopped by level 00 starts a frame showing the picture on the next tick, with nothing else written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_tick | input | 1 | One-clock pulse per raster row |
| ext_mode | input | 1 | 1: frames start on VSYNC falling edges |
| ext_vsync | input | 1 | External vertical sync |
| standby | input | 1 | Forces stopped behaviour while 1 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: control register, 1: porch register |
| wr_data | input | 16 | Write data |
| disp_tmg | output | 1 | High on picture rows |
| frame_start | output | 1 | Pulse entering a frame's first row |
| line_strobe | output | 1 | Pulse per row while running |
| ac_pol | output | 1 | Drive polarity, flips per frame |
| src_ctl | output | 2 | Source code: 0 ground, 1 blank, 2 picture |

## Verification
The bench builds the block with `ACTIVE_ROWS`=6, so a frame lasts only 10 to 22 ticks. At that length many frame boundaries fit in a short run, and the porch clamp cases can each be seen across whole frames. The short frame also lets the bench exercise the deferred effect of writes and the wait in the last trailing row under external sync, and a per-clock reference model is checked against every output.

// File: rtl/pft_pkg.sv
package pft_pkg;

  localparam int PORCH_W   = 4;
  localparam int PORCH_MIN = 2;
  localparam int PORCH_SUM = 16;

  typedef enum logic [1:0] {
    LVL_STOP  = 2'b00,
    LVL_GND   = 2'b01,
    LVL_BLANK = 2'b10,
    LVL_SHOW  = 2'b11
  } run_level_e;

  typedef enum logic [1:0] {
    SRC_GND   = 2'b00,
    SRC_BLANK = 2'b01,
    SRC_SHOW  = 2'b10
  } src_code_e;

  typedef struct packed {
    run_level_e           level;
    logic                 tmg_en;
    logic [PORCH_W-1:0]   bp;
    logic [PORCH_W-1:0]   fp;
  } frame_cfg_t;

  function automatic src_code_e src_of(run_level_e lvl);
    case (lvl)
      LVL_BLANK: src_of = SRC_BLANK;
      LVL_SHOW:  src_of = SRC_SHOW;
      default:   src_of = SRC_GND;
    endcase
  endfunction

endpackage

// File: rtl/pft_regs.sv
module pft_regs
  import pft_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output frame_cfg_t        cfg,
  output logic              stop_level
);

  localparam int SUM_W = PORCH_W + 1;

  run_level_e         level_q;
  logic               tmg_en_q;
  logic [PORCH_W-1:0] bp_q, fp_q;
  logic [SUM_W-1:0]   bp_c, fp_t, fp_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q  <= LVL_STOP;
      tmg_en_q <= 1'b0;
      bp_q     <= PORCH_W'(PORCH_MIN);
      fp_q     <= PORCH_W'(PORCH_MIN);
    end else if (wr_en) begin
      if (wr_sel) begin
        fp_q <= wr_data[8 +: PORCH_W];
        bp_q <= wr_data[0 +: PORCH_W];
      end else begin
        level_q  <= run_level_e'(wr_data[1:0]);
        tmg_en_q <= wr_data[4];
      end
    end
  end

  always_comb begin
    bp_c = (bp_q < PORCH_W'(PORCH_MIN)) ? SUM_W'(PORCH_MIN) : {1'b0, bp_q};
    fp_t = (fp_q < PORCH_W'(PORCH_MIN)) ? SUM_W'(PORCH_MIN) : {1'b0, fp_q};
    fp_c = ((bp_c + fp_t) > SUM_W'(PORCH_SUM)) ? (SUM_W'(PORCH_SUM) - bp_c) : fp_t;
  end

  assign cfg.level  = level_q;
  assign cfg.tmg_en = tmg_en_q;
  assign cfg.bp     = bp_c[PORCH_W-1:0];
  assign cfg.fp     = fp_c[PORCH_W-1:0];
  assign stop_level = (level_q == LVL_STOP);

endmodule

// File: rtl/pft_vsync.sv
module pft_vsync (
  input  logic clk,
  input  logic rst,
  input  logic ext_vsync,
  input  logic row_tick,
  output logic vs_take
);

  logic vs_q, pend_q, fall;

  assign fall    = vs_q & ~ext_vsync;
  assign vs_take = pend_q | fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      vs_q   <= ext_vsync;
      pend_q <= row_tick ? 1'b0 : vs_take;
    end
  end

endmodule

// File: rtl/pft_seq.sv
module pft_seq
  import pft_pkg::*;
#(
  parameter int ACTIVE_ROWS = 320
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       row_tick,
  input  logic       halt_req,
  input  logic       ext_mode,
  input  logic       vs_take,
  input  frame_cfg_t cfg,
  output logic       disp_tmg,
  output logic       frame_start,
  output logic       line_strobe,
  output logic       ac_pol,
  output logic [1:0] src_ctl
);

  localparam int FRAME_MAX = ACTIVE_ROWS + 2 * (1 << PORCH_W);
  localparam int POS_W     = $clog2(FRAME_MAX + 1);

  frame_cfg_t       act;
  logic             running;
  logic [POS_W-1:0] pos, nxt_pos, last_pos, bp_w, act_end;
  logic             start;

  assign bp_w     = POS_W'(act.bp);
  assign act_end  = bp_w + POS_W'(ACTIVE_ROWS);
  assign last_pos = act_end + POS_W'(act.fp) - POS_W'(1);
  assign nxt_pos  = (pos == last_pos) ? pos : pos + POS_W'(1);
  assign start    = ext_mode ? vs_take : (!running || pos == last_pos);

  always_ff @(posedge clk) begin
    if (rst) begin
      act         <= '{level: LVL_STOP, tmg_en: 1'b0,
                       bp: PORCH_W'(PORCH_MIN), fp: PORCH_W'(PORCH_MIN)};
      running     <= 1'b0;
      pos         <= '0;
      disp_tmg    <= 1'b0;
      frame_start <= 1'b0;
      line_strobe <= 1'b0;
      ac_pol      <= 1'b0;
      src_ctl     <= SRC_GND;
    end else begin
      frame_start <= 1'b0;
      line_strobe <= 1'b0;
      if (row_tick) begin
        if (halt_req) begin
          running  <= 1'b0;
          pos      <= '0;
          disp_tmg <= 1'b0;
          src_ctl  <= SRC_GND;
        end else if (start) begin
          act         <= cfg;
          running     <= 1'b1;
          pos         <= '0;
          frame_start <= 1'b1;
          line_strobe <= 1'b1;
          ac_pol      <= ~ac_pol;
          disp_tmg    <= 1'b0;
          src_ctl     <= src_of(cfg.level);
        end else if (running) begin
          pos         <= nxt_pos;
          line_strobe <= 1'b1;
          disp_tmg    <= act.tmg_en && (nxt_pos >= bp_w) && (nxt_pos < act_end);
        end
      end
    end
  end

endmodule

// File: rtl/panel_frame_timer.sv
module panel_frame_timer
  import pft_pkg::*;
#(
  parameter int ACTIVE_ROWS = 320,
  parameter int DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              row_tick,
  input  logic              ext_mode,
  input  logic              ext_vsync,
  input  logic              standby,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              disp_tmg,
  output logic              frame_start,
  output logic              line_strobe,
  output logic              ac_pol,
  output logic [1:0]        src_ctl
);

  frame_cfg_t cfg;
  logic       stop_level;
  logic       vs_take;

  pft_regs #(.DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cfg(cfg), .stop_level(stop_level)
  );

  pft_vsync vsync_i (
    .clk(clk), .rst(rst), .ext_vsync(ext_vsync),
    .row_tick(row_tick), .vs_take(vs_take)
  );

  pft_seq #(.ACTIVE_ROWS(ACTIVE_ROWS)) seq_i (
    .clk(clk), .rst(rst), .row_tick(row_tick),
    .halt_req(standby | stop_level), .ext_mode(ext_mode),
    .vs_take(vs_take), .cfg(cfg),
    .disp_tmg(disp_tmg), .frame_start(frame_start),
    .line_strobe(line_strobe), .ac_pol(ac_pol), .src_ctl(src_ctl)
  );

endmodule

// File: rtl/pft_chk.sv
module pft_chk (
  input logic       clk,
  input logic       rst,
  input logic       row_tick,
  input logic       standby,
  input logic       disp_tmg,
  input logic       frame_start,
  input logic       line_strobe,
  input logic       ac_pol,
  input logic [1:0] src_ctl
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!disp_tmg && !frame_start && !line_strobe && !ac_pol && src_ctl == 2'b00));

  p_first_row_blank_r2: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> !disp_tmg);

  p_strobe_needs_tick_r6: assert property (@(posedge clk) disable iff (rst)
    !row_tick |=> (!line_strobe && !frame_start));

  p_start_is_row_r6: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> line_strobe);

  p_pol_only_at_start_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(ac_pol) |-> frame_start);

  p_src_code_legal_r8: assert property (@(posedge clk) disable iff (rst)
    src_ctl != 2'b11);

  p_standby_stops_r9: assert property (@(posedge clk) disable iff (rst)
    (standby && row_tick) |=> (src_ctl == 2'b00 && !line_strobe && !disp_tmg));

  p_hold_between_ticks_r10: assert property (@(posedge clk) disable iff (rst)
    !row_tick |=> ($stable(src_ctl) && $stable(disp_tmg) && $stable(ac_pol)));

endmodule

bind panel_frame_timer pft_chk chk_i (
  .clk(clk), .rst(rst), .row_tick(row_tick), .standby(standby),
  .disp_tmg(disp_tmg), .frame_start(frame_start), .line_strobe(line_strobe),
  .ac_pol(ac_pol), .src_ctl(src_ctl)
);

// File: tb/panel_frame_timer_tb_top.sv
module panel_frame_timer_tb_top;

  localparam int N = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        row_tick = 1'b0, ext_mode = 1'b0, ext_vsync = 1'b1, standby = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        disp_tmg, frame_start, line_strobe, ac_pol;
  logic [1:0]  src_ctl;

  int checks = 0, errors = 0;

  always #10ns clk = ~clk;

  panel_frame_timer #(.ACTIVE_ROWS(N)) dut_i (
    .clk(clk), .rst(rst), .row_tick(row_tick), .ext_mode(ext_mode),
    .ext_vsync(ext_vsync), .standby(standby), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .disp_tmg(disp_tmg), .frame_start(frame_start),
    .line_strobe(line_strobe), .ac_pol(ac_pol), .src_ctl(src_ctl)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // reference model state
  int  s_lvl, s_tmg, s_bp, s_fp;
  int  a_lvl, a_tmg, a_bp, a_fp;
  int  m_run, m_pos, m_pend, m_vsq;
  int  m_disp, m_fs, m_ls, m_ac, m_src;

  always @(posedge clk) begin
    if (rst) begin
      s_lvl = 0; s_tmg = 0; s_bp = 2; s_fp = 2;
      a_lvl = 0; a_tmg = 0; a_bp = 2; a_fp = 2;
      m_run = 0; m_pos = 0; m_pend = 0; m_vsq = 0;
      m_disp = 0; m_fs = 0; m_ls = 0; m_ac = 0; m_src = 0;
    end else begin
      int take, last, b, f;
      take = m_pend | (m_vsq & !ext_vsync);
      last = a_bp + N + a_fp - 1;
      m_fs = 0; m_ls = 0;
      if (row_tick) begin
        if (standby || s_lvl == 0) begin
          m_run = 0; m_pos = 0; m_disp = 0; m_src = 0;
        end else if (ext_mode ? take : (!m_run || m_pos == last)) begin
          b = (s_bp < 2) ? 2 : s_bp;
          f = (s_fp < 2) ? 2 : s_fp;
          if (b + f > 16) f = 16 - b;
          a_lvl = s_lvl; a_tmg = s_tmg; a_bp = b; a_fp = f;
          m_run = 1; m_pos = 0; m_fs = 1; m_ls = 1; m_ac ^= 1; m_disp = 0;
          m_src = (s_lvl == 3) ? 2 : (s_lvl == 2) ? 1 : 0;
        end else if (m_run) begin
          if (m_pos != last) m_pos++;
          m_ls = 1;
          m_disp = (a_tmg && m_pos >= a_bp && m_pos < a_bp + N) ? 1 : 0;
        end
        m_pend = 0;
      end else m_pend = take;
      m_vsq = ext_vsync;
      if (wr_en) begin
        if (wr_sel) begin s_fp = wr_data[11:8]; s_bp = wr_data[3:0]; end
        else begin s_lvl = wr_data[1:0]; s_tmg = wr_data[4]; end
      end
    end
  end

  // per-clock comparison and event monitor
  int cnt = 0, last_len = 0, last_bp = 0, seen_disp = 0;
  int fs_cnt = 0, ls_cnt = 0, disp_cnt = 0, ac_chg = 0, ac_prev = 0;

  always @(negedge clk) begin
    if (!rst) begin
      chk("R3 disp_tmg model", disp_tmg, m_disp);
      chk("R6 frame_start model", frame_start, m_fs);
      chk("R6 line_strobe model", line_strobe, m_ls);
      chk("R7 ac_pol model", ac_pol, m_ac);
      chk("R8 src_ctl model", src_ctl, m_src);
      if (line_strobe) begin
        ls_cnt++;
        if (frame_start) begin
          fs_cnt++; last_len = cnt; cnt = 1; seen_disp = 0;
        end else cnt++;
        if (disp_tmg && !seen_disp) begin last_bp = cnt - 1; seen_disp = 1; end
      end
      if (disp_tmg) disp_cnt++;
      if (int'(ac_pol) != ac_prev) ac_chg++;
      ac_prev = ac_pol;
    end
  end

  task automatic clr();
    fs_cnt = 0; ls_cnt = 0; disp_cnt = 0; ac_chg = 0;
  endtask

  task automatic ticks(int n);
    repeat (n) begin
      @(negedge clk); row_tick = 1'b1;
      @(negedge clk); row_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic wr(logic sel, logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 disp_tmg", disp_tmg, 0);
    chk("R1 line_strobe", line_strobe, 0);
    chk("R1 ac_pol", ac_pol, 0);
    chk("R1 src_ctl", src_ctl, 0);

    // R2 R4: bp=3 fp=4, picture shown with enable
    wr(1'b1, 16'h0403);
    wr(1'b0, 16'h0013);
    clr();
    ticks(40);
    chk("R2 frame length", last_len, 3 + N + 4);
    chk("R4 leading rows", last_bp, 3);
    chk("R8 level 11 code", src_ctl, 2);
    chk("R7 flips per frame", ac_chg, fs_cnt);
    chk("R6 strobe per tick", ls_cnt, 40);

    // R5: zero porches clamp to 2
    wr(1'b1, 16'h0000);
    ticks(40);
    chk("R5 min leading", last_bp, 2);
    chk("R5 min frame", last_len, 2 + N + 2);

    // R5: 12+9 exceeds 16, trailing cut to 4
    wr(1'b1, 16'h090C);
    ticks(60);
    chk("R5 sum leading", last_bp, 12);
    chk("R5 sum frame", last_len, 12 + N + 4);

    // R3: enable off keeps disp_tmg low
    wr(1'b0, 16'h0003);
    ticks(25);
    clr();
    ticks(30);
    chk("R3 disp held low", disp_cnt, 0);

    // R8: blank and ground levels
    wr(1'b0, 16'h0002);
    ticks(25);
    chk("R8 level 10 code", src_ctl, 1);
    wr(1'b0, 16'h0001);
    ticks(25);
    chk("R8 level 01 code", src_ctl, 0);
    clr();
    ticks(20);
    chk("R8 level 01 runs", ls_cnt, 20);

    // R9 R7: standby stops, keeps polarity, stored level returns
    standby = 1'b1;
    ticks(1);
    begin
      int pol;
      pol = ac_pol;
      clr();
      ticks(10);
      chk("R9 standby no strobes", ls_cnt, 0);
      chk("R9 standby ground", src_ctl, 0);
      chk("R7 polarity held", ac_pol, pol);
    end
    wr(1'b0, 16'h0013);
    standby = 1'b0;
    clr();
    ticks(1);
    chk("R9 restart frame", fs_cnt, 1);
    chk("R9 stored level used", src_ctl, 2);

    // R10: nonzero level change deferred to frame start
    wr(1'b0, 16'h0012);
    ticks(1);
    chk("R10 deferred level", src_ctl, 2);
    ticks(25);
    chk("R10 applied level", src_ctl, 1);

    // R10 R12: level 00 acts on next tick, 11 restarts at once
    wr(1'b0, 16'h0010);
    ticks(1);
    chk("R10 stop immediate", src_ctl, 0);
    clr();
    ticks(3);
    chk("R10 stopped strobes", ls_cnt, 0);
    wr(1'b0, 16'h0013);
    clr();
    ticks(1);
    chk("R12 restart frame", fs_cnt, 1);
    chk("R12 picture code", src_ctl, 2);

    // R11: external sync
    wr(1'b1, 16'h0202);
    ext_mode = 1'b1;
    ticks(30);
    clr();
    ticks(15);
    chk("R11 no edge no frame", fs_cnt, 0);
    chk("R11 rows continue", ls_cnt, 15);
    @(negedge clk); ext_vsync = 1'b0;
    @(negedge clk); ext_vsync = 1'b1;
    clr();
    ticks(1);
    chk("R11 edge starts frame", fs_cnt, 1);
    ticks(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule